// File: doc/BRIEF.md
# Posted-CAS Latency Data Scheduler

This block sits behind a memory controller's command arbiter. It receives read and write commands that have already passed every legality check, each tagged with its bank. From them it produces the time-aligned strobes the data path needs:

- a one-cycle internal-start strobe, issued once the additive latency (AL) has elapsed;
- a read-capture enable that covers the read burst, which arrives AL+CL cycles after the command;
- a write-drive enable that covers the write burst, which begins AL+1 cycles after the command.

A burst is four double-rate beats, so each enable is high for two clock cycles. A beat index of 0 or 2 marks which pair of beats the current cycle carries. The bank of the burst is presented alongside the enables.

Cycles are counted from the command cycle, which is cycle 0. Each strobe comes out of one register stage, so an event with latency L is seen in cycle L+1.

Timing is tracked by a shift-register delay line. Each stage holds a valid bit, a read/write flag and a bank tag. Programmable taps on the delay line feed a data-direction state machine with five states:

| State | Meaning |
|---|---|
| DP_IDLE | No burst on the data path |
| DP_RD_LO | First cycle of a read burst, beats 0 and 1 |
| DP_RD_HI | Second cycle of a read burst, beats 2 and 3 |
| DP_WR_LO | First cycle of a write burst, beats 0 and 1 |
| DP_WR_HI | Second cycle of a write burst, beats 2 and 3 |

The transitions are named as follows:

| Transition | From | To | Condition |
|---|---|---|---|
| T_RD_OPEN | DP_IDLE or either HI state | DP_RD_LO | A read reaches its tap |
| T_WR_OPEN | DP_IDLE or either HI state | DP_WR_LO | Only a write reaches its tap |
| T_PAIR | Either LO state | The HI state of the same direction | Always; no burst can start here |
| T_CLOSE | Either HI state | DP_IDLE | Nothing reaches a tap |

A burst that would begin in a LO state is dropped, and the overlap flag is raised. When a read and a write would begin in the same cycle, the write is dropped.

Top module: `posted_cas_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is 0: the internal-start strobe, its flag and bank, both enables, the beat index, the burst bank and the overlap flag.
- R2: A command accepted in cycle 0 raises `ist_valid` for exactly one cycle, in cycle AL+1. In that cycle `ist_wr` equals the command's write flag (1 for write) and `ist_bank` equals its bank. Both are 0 whenever `ist_valid` is 0.
- R3: A read accepted in cycle 0 raises `rd_cap_en` in cycles AL+CL+1 and AL+CL+2 only.
- R4: A write accepted in cycle 0 raises `wr_drv_en` in cycles AL+2 and AL+3 only, so the write latency is AL+1.
- R5: In the first cycle of every burst `beat_idx` is 0, and in the second it is 2. `burst_bank` carries the command's bank in both cycles. When no burst is active, both `beat_idx` and `burst_bank` are 0.
- R6: Two commands of the same direction issued two cycles apart give abutting bursts. The enable stays high for four cycles, `beat_idx` runs 0,2,0,2, and each pair of cycles carries its own bank.
- R7: Suppose a burst would begin while another burst is in its first cycle. The new burst is dropped, the active burst finishes unchanged, and `overlap_err` is high for one cycle: the cycle in which the dropped burst would have begun.
- R8: Suppose a read burst and a write burst would begin in the same cycle. The read is kept, the write is dropped, and `overlap_err` is high in that cycle.
- R9: A burst of either direction may begin in the cycle right after the second cycle of another burst, with no overlap flag.
- R10: `cfg_cl` must lie in 2..MAX_CL, and `cfg_al` is one bit (0 or 1). Both are held stable while any command is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_al | input | 1 | Additive latency, 0 or 1 |
| cfg_cl | input | CL_W | CAS latency, 2..MAX_CL |
| cmd_valid | input | 1 | An approved command is present this cycle |
| cmd_wr | input | 1 | 1 for write, 0 for read |
| cmd_bank | input | BANK_W | Bank tag of the command |
| ist_valid | output | 1 | Internal command start strobe |
| ist_wr | output | 1 | Write flag of the started command |
| ist_bank | output | BANK_W | Bank of the started command |
| rd_cap_en | output | 1 | Read capture enable |
| wr_drv_en | output | 1 | Write drive enable |
| beat_idx | output | 2 | Even beat carried this cycle, 0 or 2 |
| burst_bank | output | BANK_W | Bank of the active burst |
| overlap_err | output | 1 | A burst was dropped for overlap |

## Verification
A wrong tap index in the delay line moves an enable or the start strobe by whole cycles. This shows up within AL+CL+3 cycles of a single isolated command, so a sweep of single commands over both AL values and a spread of CL values exposes it.

A state machine that mishandles a LO-to-HI step shows up in the second cycle of any burst: the enable drops or `beat_idx` is wrong. A machine that mishandles overlap shows up only when commands are spaced so that two burst windows touch. The bench therefore places writes at offsets that make them start together with a read, inside it, and right after it, and checks the enables and `overlap_err` cycle by cycle.

// File: rtl/pds_pkg.sv
package pds_pkg;
    parameter int PDS_BANK_W = 2;

    typedef struct packed {
        logic                  valid;
        logic                  wr;
        logic [PDS_BANK_W-1:0] bank;
    } pds_stage_t;

    typedef enum logic [2:0] {
        DP_IDLE,
        DP_RD_LO,
        DP_RD_HI,
        DP_WR_LO,
        DP_WR_HI
    } dp_state_e;
endpackage

// File: rtl/pds_delay_line.sv
module pds_delay_line
    import pds_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  pds_stage_t din,
    output pds_stage_t taps [1:DEPTH]
);
    pds_stage_t sr [1:DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr[1] <= '0;
        else        sr[1] <= din;
    end

    for (genvar g = 2; g <= DEPTH; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr[g] <= '0;
            else        sr[g] <= sr[g-1];
        end
    end

    assign taps = sr;
endmodule

// File: rtl/pds_tap_select.sv
module pds_tap_select
    import pds_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CL_W   = 4,
    parameter int BANK_W = PDS_BANK_W
) (
    input  pds_stage_t        taps [1:DEPTH],
    input  logic              cfg_al,
    input  logic [CL_W-1:0]   cfg_cl,
    output pds_stage_t        start_stage,
    output logic              rd_go,
    output logic [BANK_W-1:0] rd_bank,
    output logic              wr_go,
    output logic [BANK_W-1:0] wr_bank
);
    localparam int IDX_W = $clog2(DEPTH + 2);

    logic [IDX_W-1:0] st_idx, rl_idx, wl_idx;
    pds_stage_t       rd_t, wr_t;

    assign st_idx = IDX_W'(cfg_al) + IDX_W'(1);
    assign rl_idx = IDX_W'(cfg_al) + IDX_W'(cfg_cl);
    assign wl_idx = IDX_W'(cfg_al) + IDX_W'(1);

    always_comb begin
        start_stage = '0;
        rd_t        = '0;
        wr_t        = '0;
        for (int i = 1; i <= DEPTH; i++) begin
            if (st_idx == IDX_W'(i)) start_stage = taps[i];
            if (rl_idx == IDX_W'(i)) rd_t        = taps[i];
            if (wl_idx == IDX_W'(i)) wr_t        = taps[i];
        end
    end

    assign rd_go   = rd_t.valid && !rd_t.wr;
    assign rd_bank = rd_t.bank;
    assign wr_go   = wr_t.valid && wr_t.wr;
    assign wr_bank = wr_t.bank;
endmodule

// File: rtl/pds_burst_fsm.sv
module pds_burst_fsm
    import pds_pkg::*;
#(
    parameter int BANK_W = PDS_BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic              wr_go,
    input  logic [BANK_W-1:0] wr_bank,
    output logic              rd_en,
    output logic              wr_en,
    output logic [1:0]        beat_idx,
    output logic [BANK_W-1:0] burst_bank,
    output logic              overlap_err
);
    dp_state_e         state_q, state_d;
    logic [BANK_W-1:0] bank_q, bank_d;
    logic              ovl_q, ovl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DP_IDLE;
            bank_q  <= '0;
            ovl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            bank_q  <= bank_d;
            ovl_q   <= ovl_d;
        end
    end

    always_comb begin
        state_d = state_q;
        bank_d  = bank_q;
        ovl_d   = 1'b0;
        unique case (state_q)
            DP_RD_LO: begin
                state_d = DP_RD_HI;
                ovl_d   = rd_go || wr_go;
            end
            DP_WR_LO: begin
                state_d = DP_WR_HI;
                ovl_d   = rd_go || wr_go;
            end
            DP_IDLE, DP_RD_HI, DP_WR_HI: begin
                if (rd_go) begin
                    state_d = DP_RD_LO;
                    bank_d  = rd_bank;
                    ovl_d   = wr_go;
                end else if (wr_go) begin
                    state_d = DP_WR_LO;
                    bank_d  = wr_bank;
                end else begin
                    state_d = DP_IDLE;
                    bank_d  = '0;
                end
            end
            default: begin
                state_d = DP_IDLE;
                bank_d  = '0;
            end
        endcase
    end

    always_comb begin
        rd_en       = 1'b0;
        wr_en       = 1'b0;
        beat_idx    = 2'd0;
        burst_bank  = '0;
        overlap_err = ovl_q;
        unique case (state_q)
            DP_RD_LO: begin rd_en = 1'b1; burst_bank = bank_q; end
            DP_RD_HI: begin rd_en = 1'b1; beat_idx = 2'd2; burst_bank = bank_q; end
            DP_WR_LO: begin wr_en = 1'b1; burst_bank = bank_q; end
            DP_WR_HI: begin wr_en = 1'b1; beat_idx = 2'd2; burst_bank = bank_q; end
            default:  ;
        endcase
    end

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en)); // R7
    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && beat_idx == 2'd0) |=>
        ((rd_en || wr_en) && beat_idx == 2'd2 && rd_en == $past(rd_en))); // R5
    AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && beat_idx == 2'd2) |-> burst_bank == $past(burst_bank)); // R5
    AST_OVERLAP_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_err |-> (rd_en || wr_en)); // R7
endmodule

// File: rtl/posted_cas_sched.sv
module posted_cas_sched
    import pds_pkg::*;
#(
    parameter int MAX_CL = 15,
    parameter int BANK_W = PDS_BANK_W,
    parameter int CL_W   = $clog2(MAX_CL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_al,
    input  logic [CL_W-1:0]   cfg_cl,
    input  logic              cmd_valid,
    input  logic              cmd_wr,
    input  logic [BANK_W-1:0] cmd_bank,
    output logic              ist_valid,
    output logic              ist_wr,
    output logic [BANK_W-1:0] ist_bank,
    output logic              rd_cap_en,
    output logic              wr_drv_en,
    output logic [1:0]        beat_idx,
    output logic [BANK_W-1:0] burst_bank,
    output logic              overlap_err
);
    localparam int DEPTH = MAX_CL + 1;

    pds_stage_t        din;
    pds_stage_t        taps [1:DEPTH];
    pds_stage_t        start_stage;
    logic              rd_go, wr_go;
    logic [BANK_W-1:0] rd_bank, wr_bank;

    assign din.valid = cmd_valid;
    assign din.wr    = cmd_valid && cmd_wr;
    assign din.bank  = cmd_valid ? cmd_bank : '0;

    pds_delay_line #(.DEPTH(DEPTH)) line_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .taps  (taps)
    );

    pds_tap_select #(.DEPTH(DEPTH), .CL_W(CL_W), .BANK_W(BANK_W)) tap_i (
        .taps        (taps),
        .cfg_al      (cfg_al),
        .cfg_cl      (cfg_cl),
        .start_stage (start_stage),
        .rd_go       (rd_go),
        .rd_bank     (rd_bank),
        .wr_go       (wr_go),
        .wr_bank     (wr_bank)
    );

    pds_burst_fsm #(.BANK_W(BANK_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_go       (rd_go),
        .rd_bank     (rd_bank),
        .wr_go       (wr_go),
        .wr_bank     (wr_bank),
        .rd_en       (rd_cap_en),
        .wr_en       (wr_drv_en),
        .beat_idx    (beat_idx),
        .burst_bank  (burst_bank),
        .overlap_err (overlap_err)
    );

    assign ist_valid = start_stage.valid;
    assign ist_wr    = start_stage.valid && start_stage.wr;
    assign ist_bank  = start_stage.valid ? start_stage.bank : '0;

    AST_WR_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (ist_valid && ist_wr) |=> ((wr_drv_en && beat_idx == 2'd0) || overlap_err)); // R4

    always_ff @(posedge clk) begin
        if (rst_n) begin
            AST_CL_RANGE: assert (cfg_cl >= CL_W'(2) && int'(cfg_cl) <= MAX_CL); // R10
        end
    end
endmodule

// File: tb/posted_cas_sched_tb.sv
module posted_cas_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam int RUNLEN = 24;
    // {al, cl[3:0], wr, bank[1:0]}
    localparam logic [7:0] VEC [NV] = '{
        {1'b0, 4'd2,  1'b0, 2'd1},
        {1'b1, 4'd2,  1'b0, 2'd2},
        {1'b0, 4'd7,  1'b0, 2'd3},
        {1'b1, 4'd15, 1'b0, 2'd0},
        {1'b0, 4'd5,  1'b1, 2'd2},
        {1'b1, 4'd5,  1'b1, 2'd3},
        {1'b1, 4'd9,  1'b0, 2'd1},
        {1'b0, 4'd3,  1'b1, 2'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_al = 1'b0;
    logic [3:0] cfg_cl = 4'd5;
    logic       cmd_valid = 1'b0, cmd_wr = 1'b0;
    logic [1:0] cmd_bank = 2'd0;
    logic       ist_valid, ist_wr, rd_cap_en, wr_drv_en, overlap_err;
    logic [1:0] ist_bank, beat_idx, burst_bank;

    int n_cmp = 0, n_bad = 0;

    logic       pv [0:31];
    logic       pw [0:31];
    logic [1:0] pb [0:31];
    logic [10:0] obs [0:31];

    always #(CLK_PERIOD/2) clk = ~clk;

    posted_cas_sched dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_al(cfg_al), .cfg_cl(cfg_cl),
        .cmd_valid(cmd_valid), .cmd_wr(cmd_wr), .cmd_bank(cmd_bank),
        .ist_valid(ist_valid), .ist_wr(ist_wr), .ist_bank(ist_bank),
        .rd_cap_en(rd_cap_en), .wr_drv_en(wr_drv_en), .beat_idx(beat_idx),
        .burst_bank(burst_bank), .overlap_err(overlap_err)
    );

    function automatic logic [10:0] pack_now();
        return {ist_valid, ist_wr, ist_bank, rd_cap_en, wr_drv_en, beat_idx,
                burst_bank, overlap_err};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_plan();
        for (int i = 0; i < 32; i++) begin
            pv[i] = 1'b0; pw[i] = 1'b0; pb[i] = 2'd0;
        end
    endtask

    // obs[c] holds outputs seen in cycle c; the command for cycle c is driven after sampling
    task automatic run(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            obs[c]    = pack_now();
            cmd_valid = pv[c];
            cmd_wr    = pw[c];
            cmd_bank  = pb[c];
        end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [10:0] e;
        // R1: outputs during reset and the first cycle after it
        repeat (3) @(negedge clk);
        check("R1 in reset", 32'(pack_now()), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 32'(pack_now()), 32'd0);

        // vector table: single commands, per-cycle comparison (R2 R3 R4 R5)
        for (int v = 0; v < NV; v++) begin
            int al, cl, wr, bk;
            al = int'(VEC[v][7]); cl = int'(VEC[v][6:3]);
            wr = int'(VEC[v][2]); bk = int'(VEC[v][1:0]);
            cfg_al = VEC[v][7]; cfg_cl = VEC[v][6:3];
            clear_plan();
            pv[1] = 1'b1; pw[1] = VEC[v][2]; pb[1] = VEC[v][1:0];
            run(RUNLEN);
            for (int c = 0; c < RUNLEN; c++) begin
                int k;
                logic st, rd, wrd, hi;
                k   = c - 1;
                st  = (k == al + 1);
                rd  = (wr == 0) && (k == al + cl + 1 || k == al + cl + 2);
                wrd = (wr == 1) && (k == al + 2 || k == al + 3);
                hi  = (rd && k == al + cl + 2) || (wrd && k == al + 3);
                e = {st, st & wr[0], st ? bk[1:0] : 2'd0, rd, wrd,
                     hi ? 2'd2 : 2'd0, (rd | wrd) ? bk[1:0] : 2'd0, 1'b0};
                check($sformatf("R2/R3/R4/R5 vec%0d cyc%0d", v, k), 32'(obs[c]), 32'(e));
            end
        end

        // R6: two reads two cycles apart, AL=1 CL=3 -> bursts in cycles 5..8
        cfg_al = 1'b1; cfg_cl = 4'd3;
        clear_plan();
        pv[1] = 1'b1; pb[1] = 2'd1;
        pv[3] = 1'b1; pb[3] = 2'd2;
        run(RUNLEN);
        // obs index = cycle + 1; fields rd[6], beat[4:3], bank[2:1]
        check("R6 rd cyc5", 32'(obs[6][6:1]),  32'({1'b1, 1'b0, 2'd0, 2'd1}));
        check("R6 rd cyc6", 32'(obs[7][6:1]),  32'({1'b1, 1'b0, 2'd2, 2'd1}));
        check("R6 rd cyc7", 32'(obs[8][6:1]),  32'({1'b1, 1'b0, 2'd0, 2'd2}));
        check("R6 rd cyc8", 32'(obs[9][6:1]),  32'({1'b1, 1'b0, 2'd2, 2'd2}));
        check("R6 idle cyc9", 32'(obs[10][6:1]), 32'd0);

        // R8: read at 0 (AL=0 CL=5 -> 6,7) and write at 4 (-> 6,7): write dropped
        cfg_al = 1'b0; cfg_cl = 4'd5;
        clear_plan();
        pv[1] = 1'b1; pb[1] = 2'd3;
        pv[5] = 1'b1; pw[5] = 1'b1; pb[5] = 2'd1;
        run(RUNLEN);
        check("R8 cyc6 read kept+flag", 32'(obs[7][6:0]),  32'({1'b1, 1'b0, 2'd0, 2'd3, 1'b1}));
        check("R8 cyc7 read intact",    32'(obs[8][6:0]),  32'({1'b1, 1'b0, 2'd2, 2'd3, 1'b0}));
        check("R8 no write later",      32'(obs[9][6:0]),  32'd0);

        // R7: write at 5 would start in cycle 7 (inside the read): dropped
        clear_plan();
        pv[1] = 1'b1; pb[1] = 2'd2;
        pv[6] = 1'b1; pw[6] = 1'b1; pb[6] = 2'd1;
        run(RUNLEN);
        check("R7 cyc6 read, no flag",  32'(obs[7][6:0]),  32'({1'b1, 1'b0, 2'd0, 2'd2, 1'b0}));
        check("R7 cyc7 read + flag",    32'(obs[8][6:0]),  32'({1'b1, 1'b0, 2'd2, 2'd2, 1'b1}));
        check("R7 cyc8 nothing",        32'(obs[9][6:0]),  32'd0);

        // R9: write at 6 starts in cycle 8, right after the read ends
        clear_plan();
        pv[1] = 1'b1; pb[1] = 2'd2;
        pv[7] = 1'b1; pw[7] = 1'b1; pb[7] = 2'd3;
        run(RUNLEN);
        check("R9 cyc7 read hi",   32'(obs[8][6:0]),  32'({1'b1, 1'b0, 2'd2, 2'd2, 1'b0}));
        check("R9 cyc8 write lo",  32'(obs[9][6:0]),  32'({1'b0, 1'b1, 2'd0, 2'd3, 1'b0}));
        check("R9 cyc9 write hi",  32'(obs[10][6:0]), 32'({1'b0, 1'b1, 2'd2, 2'd3, 1'b0}));

        // R1: reset in the middle of a burst clears every output
        clear_plan();
        pv[1] = 1'b1; pb[1] = 2'd1;
        run(7);
        check("R1 burst active before reset", 32'(rd_cap_en), 32'd1);
        rst_n = 1'b0;
        #1;
        check("R1 mid-burst reset", 32'(pack_now()), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (RUNLEN) begin
            @(negedge clk);
            check("R1 stays idle after reset", 32'(pack_now()), 32'd0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule